// File: doc/BRIEF.md
# Chroma Subcarrier Synthesizer and Quadrature Modulator

This block makes the colour subcarrier of an analog television encoder by direct digital synthesis and modulates two signed colour-difference samples (B-Y and R-Y) onto it. It produces one signed chrominance sample per clock. The block runs from a single clock at twice the pixel rate. A 32-bit phase accumulator advances by a register-supplied increment on every clock. Its upper bits address a quarter-wave sine table, which returns a sine and a cosine together.

An external sync generator supplies two gates. The video gate marks active picture and the burst gate marks the colour-burst window. During active video the output is the quadrature sum of the colour-difference inputs. During burst it is a sine wave whose amplitude is set by an input. At all other times it is zero. Each interval adds its own phase offset to the accumulator phase, so changing the video offset relative to the burst offset shifts hue without moving the burst. A strobe at the start of line 1 of field 1 returns the accumulator to phase zero.

Top module: `chroma_sc_mod`

## Requirements
- R1: While `rst` is high, and on the first clock after it falls, `chroma_out` is 0 and the accumulator holds 0.
- R2: On every clock without `rst` or `line1_strobe`, the accumulator adds `freq_inc` modulo 2^32. The phase used for lookup is its top 10 bits, P = acc[31:22].
- R3: `line1_strobe` high at a clock edge loads the accumulator with 0 in place of the increment.
- R4: With `video_gate` high, the output is floor((b_y·S(Pv) + r_y·S(Pv+256)) / 256), where Pv = (P + `video_phase_ofs`) mod 1024. Here b_y and r_y are two's complement.
- R5: With only `burst_gate` high, the output is floor(`burst_amp`·S(Pb) / 256), where Pb = (P + `burst_phase_ofs`) mod 1024 and `burst_amp` is unsigned.
- R6: `video_gate` has priority over `burst_gate`. With both gates low, the output is 0 whatever b_y, r_y and `burst_amp` hold.
- R7: The video offset acts only during the video gate and the burst offset acts only during the burst gate. Changing one leaves the other interval's output unchanged.
- R8: S(p) = round(511·sin(2π(p+0.5)/1024)), with halves rounded away from zero. The cosine is S(p+256).
- R9: The inputs and accumulator value present at clock edge k appear on `chroma_out` after edge k+1: two register stages. No output change is visible after edge k.
- R10: `chroma_out` always stays within −511 to +511.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the pixel rate |
| rst | input | 1 | Synchronous active-high reset |
| line1_strobe | input | 1 | Clears the accumulator at the start of line 1, field 1 |
| freq_inc | input | 32 | Phase increment per clock |
| burst_phase_ofs | input | 10 | Phase offset used in the burst window |
| video_phase_ofs | input | 10 | Phase offset used in active video (hue) |
| burst_amp | input | 8 | Unsigned burst amplitude |
| burst_gate | input | 1 | Burst window from the sync generator |
| video_gate | input | 1 | Active-video window from the sync generator |
| b_y | input | 8 | Signed B-Y sample |
| r_y | input | 8 | Signed R-Y sample |
| chroma_out | output | 10 | Signed chrominance sample |

## Verification
The bench steps the phase by exactly one table entry per clock across a full turn. A quadrant-folding error, such as a missing index mirror, a sign taken from the wrong bit, or a cosine that is not a quarter turn ahead, then shows up as a wrong sample at the quadrant seams. It drives the extreme colour-difference values −128 and +127 and a burst amplitude of 255, which would expose truncation towards zero instead of floor, or an overflowing sum. It toggles the two gates independently and together, and changes the video offset between lines while the burst offset stays fixed. An offset applied to the wrong interval, or a reversed priority, therefore gives wrong burst or video samples. Line strobes mid-run and a gate edge timed against the output catch an accumulator that keeps counting on a strobe and an output that arrives one cycle early or late.

// File: rtl/chroma_pkg.sv
package chroma_pkg;

  typedef enum logic [1:0] {
    SEL_IDLE   = 2'd0,
    SEL_BURST  = 2'd1,
    SEL_ACTIVE = 2'd2
  } chroma_sel_e;

  localparam real TWO_PI = 6.283185307179586;

  // Quarter-wave entry k of a table with qdepth entries per quadrant,
  // sampled half a step off zero so that the quadrants mirror exactly.
  function automatic int qwave_entry(input int k, input int qdepth, input int amp);
    real x;
    x = real'(amp) * $sin(TWO_PI * (real'(k) + 0.5) / real'(4 * qdepth));
    return $rtoi(x + 0.5);
  endfunction

endpackage

// File: rtl/sc_phase_accum.sv
module sc_phase_accum #(
  parameter int ACC_W = 32,
  parameter int PH_W  = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [ACC_W-1:0] inc,
  output logic [ACC_W-1:0] acc_q,
  output logic [PH_W-1:0]  phase
);

  always_ff @(posedge clk) begin
    if (rst || clr) acc_q <= '0;
    else            acc_q <= acc_q + inc;
  end

  assign phase = acc_q[ACC_W-1 -: PH_W];

endmodule

// File: rtl/sc_sine_rom.sv
module sc_sine_rom
  import chroma_pkg::*;
#(
  parameter int PH_W  = 10,
  parameter int SIN_W = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [PH_W-1:0]         ph_a,
  input  logic [PH_W-1:0]         ph_b,
  output logic signed [SIN_W-1:0] sin_a,
  output logic signed [SIN_W-1:0] sin_b
);

  localparam int QBITS  = PH_W - 2;
  localparam int QDEPTH = 1 << QBITS;
  localparam int MAG_W  = SIN_W - 1;
  localparam int AMP    = (1 << (SIN_W - 1)) - 1;

  logic [MAG_W-1:0] qrom [QDEPTH];

  initial begin
    for (int i = 0; i < QDEPTH; i++) qrom[i] = MAG_W'(qwave_entry(i, QDEPTH, AMP));
  end

  logic [PH_W-1:0]         ph  [2];
  logic signed [SIN_W-1:0] val [2];

  assign ph[0] = ph_a;
  assign ph[1] = ph_b;

  generate
    for (genvar g = 0; g < 2; g++) begin : g_port
      logic [QBITS-1:0] idx;
      logic [MAG_W-1:0] mag_q;
      logic             neg_q;

      // odd quadrants run the quarter table backwards
      assign idx = ph[g][QBITS] ? ~ph[g][QBITS-1:0] : ph[g][QBITS-1:0];

      // registered read without reset so the table maps onto block RAM
      always_ff @(posedge clk) begin
        mag_q <= qrom[idx];
      end

      always_ff @(posedge clk) begin
        if (rst) neg_q <= 1'b0;
        else     neg_q <= ph[g][PH_W-1];
      end

      assign val[g] = neg_q ? -$signed({1'b0, mag_q}) : $signed({1'b0, mag_q});
    end
  endgenerate

  assign sin_a = val[0];
  assign sin_b = val[1];

endmodule

// File: rtl/sc_quad_mac.sv
module sc_quad_mac
  import chroma_pkg::*;
#(
  parameter int IN_W  = 8,
  parameter int SIN_W = 10,
  parameter int AMP_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  chroma_sel_e             sel,
  input  logic signed [IN_W-1:0]  b_y,
  input  logic signed [IN_W-1:0]  r_y,
  input  logic [AMP_W-1:0]        amp,
  input  logic signed [SIN_W-1:0] sin_v,
  input  logic signed [SIN_W-1:0] cos_v,
  output logic signed [SIN_W-1:0] out_q
);

  localparam int PROD_W  = IN_W + SIN_W;
  localparam int SUM_W   = PROD_W + 1;
  localparam int BPROD_W = AMP_W + 1 + SIN_W;

  logic signed [PROD_W-1:0]  p_b;
  logic signed [PROD_W-1:0]  p_r;
  logic signed [SUM_W-1:0]   act_sum;
  logic signed [BPROD_W-1:0] burst_p;

  assign p_b     = b_y * sin_v;
  assign p_r     = r_y * cos_v;
  assign act_sum = p_b + p_r;
  assign burst_p = $signed({1'b0, amp}) * sin_v;

  // dropping the low bits of a two's-complement value floors it
  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= '0;
    end else begin
      unique case (sel)
        SEL_ACTIVE: out_q <= act_sum[IN_W+SIN_W-1:IN_W];
        SEL_BURST:  out_q <= burst_p[AMP_W+SIN_W-1:AMP_W];
        default:    out_q <= '0;
      endcase
    end
  end

endmodule

// File: rtl/chroma_sc_mod.sv
module chroma_sc_mod
  import chroma_pkg::*;
#(
  parameter int ACC_W = 32,
  parameter int PH_W  = 10,
  parameter int SIN_W = 10,
  parameter int IN_W  = 8,
  parameter int AMP_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    line1_strobe,
  input  logic [ACC_W-1:0]        freq_inc,
  input  logic [PH_W-1:0]         burst_phase_ofs,
  input  logic [PH_W-1:0]         video_phase_ofs,
  input  logic [AMP_W-1:0]        burst_amp,
  input  logic                    burst_gate,
  input  logic                    video_gate,
  input  logic signed [IN_W-1:0]  b_y,
  input  logic signed [IN_W-1:0]  r_y,
  output logic signed [SIN_W-1:0] chroma_out
);

  localparam logic [PH_W-1:0] QUARTER = PH_W'(1) << (PH_W - 2);

  logic [ACC_W-1:0] acc_q;
  logic [PH_W-1:0]  phase;
  chroma_sel_e      sel_d, sel_q;
  logic [PH_W-1:0]  ph_sin, ph_cos;
  logic signed [IN_W-1:0]  by_q, ry_q;
  logic [AMP_W-1:0]        amp_q;
  logic signed [SIN_W-1:0] sin_v, cos_v;

  sc_phase_accum #(.ACC_W(ACC_W), .PH_W(PH_W)) u_accum (
    .clk(clk), .rst(rst), .clr(line1_strobe), .inc(freq_inc),
    .acc_q(acc_q), .phase(phase)
  );

  always_comb begin
    if (video_gate)      sel_d = SEL_ACTIVE;
    else if (burst_gate) sel_d = SEL_BURST;
    else                 sel_d = SEL_IDLE;
  end

  assign ph_sin = phase + ((sel_d == SEL_ACTIVE) ? video_phase_ofs : burst_phase_ofs);
  assign ph_cos = ph_sin + QUARTER;

  sc_sine_rom #(.PH_W(PH_W), .SIN_W(SIN_W)) u_rom (
    .clk(clk), .rst(rst), .ph_a(ph_sin), .ph_b(ph_cos),
    .sin_a(sin_v), .sin_b(cos_v)
  );

  // first stage: align the data with the table read
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= SEL_IDLE;
      by_q  <= '0;
      ry_q  <= '0;
      amp_q <= '0;
    end else begin
      sel_q <= sel_d;
      by_q  <= b_y;
      ry_q  <= r_y;
      amp_q <= burst_amp;
    end
  end

  sc_quad_mac #(.IN_W(IN_W), .SIN_W(SIN_W), .AMP_W(AMP_W)) u_mac (
    .clk(clk), .rst(rst), .sel(sel_q), .b_y(by_q), .r_y(ry_q), .amp(amp_q),
    .sin_v(sin_v), .cos_v(cos_v), .out_q(chroma_out)
  );

endmodule

module chroma_sc_chk #(
  parameter int ACC_W = 32,
  parameter int SIN_W = 10
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    line1_strobe,
  input logic [ACC_W-1:0]        freq_inc,
  input logic                    burst_gate,
  input logic                    video_gate,
  input logic signed [SIN_W-1:0] chroma_out,
  input logic [ACC_W-1:0]        acc_q
);

  localparam int LIM = (1 << (SIN_W - 1)) - 1;

  logic [1:0] since;
  always_ff @(posedge clk) begin
    if (rst)                since <= 2'd0;
    else if (since != 2'd3) since <= since + 2'd1;
  end

  // R1
  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (chroma_out == '0 && acc_q == '0));

  // R2
  a_r2_acc_step: assert property (@(posedge clk) disable iff (rst)
    (since >= 2'd1 && !$past(line1_strobe)) |-> acc_q == $past(acc_q) + $past(freq_inc));

  // R3
  a_r3_line1_clear: assert property (@(posedge clk) disable iff (rst)
    (since >= 2'd1 && $past(line1_strobe)) |-> acc_q == '0);

  // R6 with R9 timing
  a_r6_idle_zero: assert property (@(posedge clk) disable iff (rst)
    (since >= 2'd2 && !$past(video_gate, 2) && !$past(burst_gate, 2)) |-> chroma_out == '0);

  // R10
  a_r10_range: assert property (@(posedge clk) disable iff (rst)
    (int'(chroma_out) >= -LIM && int'(chroma_out) <= LIM));

endmodule

bind chroma_sc_mod chroma_sc_chk #(.ACC_W(ACC_W), .SIN_W(SIN_W)) u_chk (
  .clk(clk), .rst(rst), .line1_strobe(line1_strobe), .freq_inc(freq_inc),
  .burst_gate(burst_gate), .video_gate(video_gate), .chroma_out(chroma_out),
  .acc_q(acc_q)
);

// File: tb/tb_chroma_sc_mod.sv
`timescale 1ns/1ps
module tb_chroma_sc_mod;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              line1_strobe = 1'b0;
  logic [31:0]       freq_inc = '0;
  logic [9:0]        burst_phase_ofs = '0;
  logic [9:0]        video_phase_ofs = '0;
  logic [7:0]        burst_amp = '0;
  logic              burst_gate = 1'b0;
  logic              video_gate = 1'b0;
  logic signed [7:0] b_y = '0;
  logic signed [7:0] r_y = '0;
  logic signed [9:0] chroma_out;

  int    checks = 0;
  int    errors = 0;
  int    cycles = 0;
  bit    done = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  chroma_sc_mod dut (
    .clk(clk), .rst(rst), .line1_strobe(line1_strobe), .freq_inc(freq_inc),
    .burst_phase_ofs(burst_phase_ofs), .video_phase_ofs(video_phase_ofs),
    .burst_amp(burst_amp), .burst_gate(burst_gate), .video_gate(video_gate),
    .b_y(b_y), .r_y(r_y), .chroma_out(chroma_out)
  );

  // ideal sine sample, R8
  function automatic int sinv(int p);
    real x;
    x = 511.0 * $sin(6.283185307179586 * (real'(p & 1023) + 0.5) / 1024.0);
    if (x >= 0.0) return $rtoi(x + 0.5);
    return -$rtoi(-x + 0.5);
  endfunction

  // reference model: accumulator plus a two-deep queue of expected outputs
  bit [31:0] m_acc = '0;
  int        exp_q[$];

  function automatic int model_now();
    int top, p;
    top = int'(m_acc[31:22]);
    if (video_gate) begin
      p = (top + int'(video_phase_ofs)) & 1023;
      return (int'(b_y) * sinv(p) + int'(r_y) * sinv(p + 256)) >>> 8;
    end
    if (burst_gate) begin
      p = (top + int'(burst_phase_ofs)) & 1023;
      return (int'(burst_amp) * sinv(p)) >>> 8;
    end
    return 0;
  endfunction

  int exp_now = 0;
  initial begin exp_q.push_back(0); exp_q.push_back(0); end

  always @(posedge clk) begin
    if (rst) begin
      m_acc = '0;
      exp_q = '{0, 0};
    end else begin
      exp_q.push_back(model_now());
      void'(exp_q.pop_front());
      m_acc = line1_strobe ? 32'd0 : m_acc + freq_inc;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (int'(chroma_out) != exp_q[0]) begin
        errors++;
        $display("FAIL %s: chroma_out=%0d expected=%0d at cycle %0d",
                 cur_req, chroma_out, exp_q[0], cycles);
      end
      checks++;
      if (int'(chroma_out) > 511 || int'(chroma_out) < -511) begin
        errors++;
        $display("FAIL R10: chroma_out=%0d expected within -511..511", chroma_out);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: cycles=%0d expected below 20000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  initial begin
    // R1: reset holds the output at zero
    step(4);
    chk("R1 reset output", int'(chroma_out), 0);
    rst = 1'b0;
    step(1);
    chk("R1 first cycle after reset", int'(chroma_out), 0);

    // R9: latency of a gate edge, phase held at zero
    cur_req = "R9";
    freq_inc = '0;
    line1_strobe = 1'b1; step(1); line1_strobe = 1'b0;
    b_y = 8'sd100; r_y = 8'sd100; video_phase_ofs = '0;
    step(3);
    video_gate = 1'b1;
    step(1);
    chk("R9 no output after one edge", int'(chroma_out), 0);
    step(1);
    chk("R9 output after two edges", int'(chroma_out),
        (100 * sinv(0) + 100 * sinv(256)) >>> 8);

    // R8: one table step per clock over a full turn
    cur_req = "R8";
    b_y = 8'sd127; r_y = 8'sd0;
    freq_inc = 32'h0040_0000;
    step(1030);
    b_y = 8'sd0; r_y = -8'sd128;
    step(1030);

    // R2: larger and odd increments with wrap
    cur_req = "R2";
    b_y = 8'sd0; r_y = 8'sd127;
    for (int i = 0; i < 3; i++) begin
      freq_inc = $urandom;
      step(150);
    end

    // R4: random colour-difference data, extremes included
    cur_req = "R4";
    freq_inc = 32'h21F0_7C1F;
    for (int i = 0; i < 300; i++) begin
      if (i % 50 == 0)      begin b_y = -8'sd128; r_y = -8'sd128; end
      else if (i % 50 == 1) begin b_y = 8'sd127;  r_y = -8'sd128; end
      else begin b_y = 8'($urandom); r_y = 8'($urandom); end
      step(1);
    end

    // R5: burst only, several amplitudes and offsets
    cur_req = "R5";
    video_gate = 1'b0; burst_gate = 1'b1;
    for (int i = 0; i < 4; i++) begin
      burst_amp = (i == 0) ? 8'd0 : (i == 1) ? 8'd255 : 8'($urandom);
      burst_phase_ofs = 10'($urandom);
      b_y = 8'($urandom); r_y = 8'($urandom);
      step(120);
    end

    // R7: lines with fixed burst offset and changing video offset
    cur_req = "R7";
    burst_phase_ofs = 10'd640; burst_amp = 8'd90;
    for (int ln = 0; ln < 6; ln++) begin
      video_phase_ofs = 10'(ln * 171);
      video_gate = 1'b0; burst_gate = 1'b1;
      step(20);
      burst_gate = 1'b0; step(4);
      video_gate = 1'b1;
      for (int i = 0; i < 60; i++) begin
        b_y = 8'($urandom); r_y = 8'($urandom); step(1);
      end
      video_gate = 1'b0; step(4);
    end

    // R6: gates toggled independently and together
    cur_req = "R6";
    for (int i = 0; i < 300; i++) begin
      video_gate = 1'($urandom); burst_gate = 1'($urandom);
      b_y = 8'($urandom); r_y = 8'($urandom); burst_amp = 8'($urandom);
      step(1);
    end

    // R3: line strobes in the middle of running phase
    cur_req = "R3";
    freq_inc = $urandom;
    for (int i = 0; i < 400; i++) begin
      line1_strobe = (i % 37 == 5);
      video_gate = 1'($urandom); burst_gate = 1'($urandom);
      b_y = 8'($urandom); r_y = 8'($urandom);
      step(1);
    end
    line1_strobe = 1'b0;

    // R1: reset in mid-stream returns output to zero
    cur_req = "R1";
    video_gate = 1'b1;
    rst = 1'b1; step(3);
    chk("R1 reset mid-stream", int'(chroma_out), 0);
    rst = 1'b0; step(10);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule